// File: doc/BRIEF.md
# Dual-Channel Shared-Counter PWM Generator

This block drives two pulse-width-modulated logic outputs from one shared time base. A phase stage passes every second system clock to a programmable down-counting prescaler. Each terminal count of the prescaler advances a period counter that runs from 0 to 254 and then returns to 0. Each channel compares its own 8-bit duty byte with the shared count. The registered output is LOW while the duty byte is strictly greater than the count, and HIGH otherwise.

A small write port loads three byte registers: the prescaler reload value and the two duty values. A combinational read port returns them. A new duty value acts on the very next comparison. A new reload value is taken only when the prescaler next reaches zero, so the division cycle in progress is not cut short.

The time base is a two-state machine. `TB_REST` is the clock in which the prescaler holds. `TB_TICK` is the clock in which the prescaler decrements, or reloads and steps the period counter. The only transitions are `TB_REST -> TB_TICK` and `TB_TICK -> TB_REST`, one per clock. Reset enters `TB_REST`.

Top module: `dual_pwm`

## Requirements
- R1: A synchronous active-high `rst` clears the prescaler count, the period counter, the reload register and both duty registers. While reset is applied and after it is released, both outputs are HIGH, and every register address reads back 00h.
- R2: The period counter counts 0, 1, ..., 254 and then returns to 0. With reload 0 and duty FEh, an output period lasts 510 clocks.
- R3: Counter steps are spaced 2 × (reload + 1) system clocks apart. With reload 3 and duty FEh, an output period lasts 2040 clocks, of which 8 are HIGH.
- R4: Each channel output is LOW while its duty byte is strictly greater than the shared count, and HIGH when the duty byte is equal to or less than the count.
- R5: A duty value of 00h gives a constantly HIGH output.
- R6: A duty value of FFh gives a constantly LOW output.
- R7: A write to a duty register is stored at the clock edge of the write. The output follows the new value one clock later, with no wait for the end of the period.
- R8: The read data is combinational from `addr`: address 0 returns the reload register, 1 returns channel 0 duty, 2 returns channel 1 duty, and 3 returns 00h. Writes to address 3 change nothing. The live prescaler count is never readable.
- R9: A reload write made while the prescaler is counting down is taken only when the prescaler next reaches zero.
- R10: Each output is registered. It reflects the duty and count values held one clock earlier.
- R11: Both channels use the same prescaler and period counter. Only the duty byte differs between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 reload, 1 duty ch0, 2 duty ch1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pwm_o | output | 2 | Channel outputs, bit n is channel n |

## Verification
The hardest case to reach is a reload change that lands in the middle of a long prescaler countdown. Only the step spacing of the period counter shows whether the old division cycle ran to its end. To reach it, the stimulus first loads a large reload value and lets a few steps pass. It then writes a small value at an arbitrary clock within the countdown. A cycle-accurate reference model checks every output clock before and after the change, and it also covers duty rewrites made mid-period on both channels.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;

    // Time-base phase: the prescaler only moves in TB_TICK
    typedef enum logic {
        TB_REST = 1'b0,
        TB_TICK = 1'b1
    } tb_phase_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int DW     = 8,
    parameter int NUM_CH = 2,
    parameter int AW     = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              reload_q,
    output logic [NUM_CH-1:0][DW-1:0]  duty_q,
    output logic [DW-1:0]              rdata
);

    localparam logic [AW-1:0] SEL_RELOAD = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (wr_en && addr == SEL_RELOAD) begin
            reload_q <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
        localparam logic [AW-1:0] SEL = AW'(g + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                duty_q[g] <= '0;
            end else if (wr_en && addr == SEL) begin
                duty_q[g] <= wdata;
            end
        end

        // R7: written duty is held from the edge of the write
        assert_duty_load_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en) && $past(addr) == SEL && !$past(rst)) |-> (duty_q[g] == $past(wdata)));
    end

    always_comb begin
        rdata = '0;
        if (addr == SEL_RELOAD) begin
            rdata = reload_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == AW'(c + 1)) begin
                rdata = duty_q[c];
            end
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import dual_pwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] reload,
    output logic [DW-1:0] cnt_q
);

    localparam logic [DW-1:0] CNT_LAST = {{(DW-1){1'b1}}, 1'b0};

    tb_phase_e     phase_q, phase_d;
    logic          tick;
    logic [DW-1:0] pre_q;

    // next-state logic
    always_comb begin
        phase_d = TB_REST;
        unique case (phase_q)
            TB_REST: phase_d = TB_TICK;
            TB_TICK: phase_d = TB_REST;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= TB_REST;
        else     phase_q <= phase_d;
    end

    // state outputs
    always_comb begin
        tick = 1'b0;
        unique case (phase_q)
            TB_REST: tick = 1'b0;
            TB_TICK: tick = 1'b1;
        endcase
    end

    // prescaler (down-counter, reloads at zero) and period counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (pre_q == '0) begin
                pre_q <= reload;
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);

    assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |->
            ((cnt_q == $past(cnt_q) + 1'b1) || ($past(cnt_q) == CNT_LAST && cnt_q == '0)));

    assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> ($past(phase_q) == TB_TICK));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] duty,
    input  logic [DW-1:0] cnt,
    output logic          pwm_q
);

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b1;
        else     pwm_q <= !(duty > cnt);
    end

    assert_zero_high_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(duty) == '0) |-> pwm_q);

    assert_full_low_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(duty) == '1 && !$past(rst)) |-> !pwm_q);

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm #(
    parameter int DW     = 8,
    parameter int NUM_CH = 2,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [DW-1:0]             reload;
    logic [NUM_CH-1:0][DW-1:0] duty;
    logic [DW-1:0]             cnt;

    pwm_regs #(.DW(DW), .NUM_CH(NUM_CH), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .reload_q (reload),
        .duty_q   (duty),
        .rdata    (rdata)
    );

    pwm_timebase #(.DW(DW)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .cnt_q  (cnt)
    );

    // R11: every channel taps the single shared count
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan #(.DW(DW)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .duty  (duty[g]),
            .cnt   (cnt),
            .pwm_q (pwm_o[g])
        );
    end

endmodule

// File: tb/dual_pwm_tb.sv
module dual_pwm_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [1:0] pwm_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_pwm u_dut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .pwm_o (pwm_o)
    );

    typedef struct packed {
        logic       in_rst;
        logic [1:0] exp;
        logic [7:0] d0;
        logic [7:0] d1;
    } item_t;

    item_t sb_q[$];

    // reference model, built from the requirements
    logic       m_phase;
    logic [7:0] m_pre, m_cnt, m_rel;
    logic [7:0] m_duty [2];

    always @(posedge clk) begin
        item_t it;
        if (rst) begin
            m_phase = 1'b0; m_pre = 8'd0; m_cnt = 8'd0; m_rel = 8'd0;
            m_duty[0] = 8'd0; m_duty[1] = 8'd0;
            it = '{in_rst: 1'b1, exp: 2'b11, d0: 8'd0, d1: 8'd0};
        end else begin
            it.in_rst = 1'b0;
            it.exp[0] = !(m_duty[0] > m_cnt);
            it.exp[1] = !(m_duty[1] > m_cnt);
            it.d0 = m_duty[0];
            it.d1 = m_duty[1];
            if (m_phase) begin
                if (m_pre == 8'd0) begin
                    m_pre = m_rel;
                    m_cnt = (m_cnt == 8'd254) ? 8'd0 : m_cnt + 8'd1;
                end else begin
                    m_pre = m_pre - 8'd1;
                end
            end
            m_phase = ~m_phase;
            if (wr_en) begin
                case (addr)
                    2'd0: m_rel = wdata;
                    2'd1: m_duty[0] = wdata;
                    2'd2: m_duty[1] = wdata;
                    default: ;
                endcase
            end
        end
        sb_q.push_back(it);
    end

    function automatic string tag_of(logic in_rst, logic [7:0] d);
        if (in_rst) return "R1";
        if (d == 8'h00) return "R5";
        if (d == 8'hFF) return "R6";
        return "R4 R7 R10 R11";
    endfunction

    // monitor: pops and compares once per clock
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (pwm_o[0] !== it.exp[0]) begin
                errors++;
                $display("FAIL %s ch0: actual %b expected %b", tag_of(it.in_rst, it.d0), pwm_o[0], it.exp[0]);
            end
            if (pwm_o[1] !== it.exp[1]) begin
                errors++;
                $display("FAIL %s ch1: actual %b expected %b", tag_of(it.in_rst, it.d1), pwm_o[1], it.exp[1]);
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #0.5;
        check(rdata === exp, req, int'(rdata), int'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // period and HIGH time of channel 0, measured between two rising edges
    task automatic measure(output int per, output int hi);
        logic prev, cur, done;
        prev = pwm_o[0]; done = 1'b0;
        while (!done) begin
            @(negedge clk); cur = pwm_o[0];
            if (!prev && cur) done = 1'b1;
            prev = cur;
        end
        per = 0; hi = 1; done = 1'b0;
        while (!done) begin
            @(negedge clk); cur = pwm_o[0]; per++;
            if (!prev && cur) done = 1'b1;
            else if (cur) hi++;
            prev = cur;
        end
    endtask

    task automatic count_level(input int ch, input logic lvl, input int n, output int seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_o[ch] == lvl) seen++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per, hi, seen;
        rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 8'd0;
        idle(4);
        // R1: reset state while reset is applied
        check(pwm_o === 2'b11, "R1", int'(pwm_o), 3);
        rst = 1'b0;
        read_check(2'd0, 8'h00, "R1");
        read_check(2'd1, 8'h00, "R1");
        read_check(2'd2, 8'h00, "R1");
        // R5: 00h gives HIGH over a whole period
        count_level(0, 1'b0, 600, seen);
        check(seen == 0, "R5", seen, 0);

        // R8: readback of each register, and the unused address
        write_reg(2'd1, 8'h40);
        write_reg(2'd2, 8'hC0);
        write_reg(2'd3, 8'h77);
        read_check(2'd0, 8'h00, "R8");
        read_check(2'd1, 8'h40, "R8");
        read_check(2'd2, 8'hC0, "R8");
        read_check(2'd3, 8'h00, "R8");
        // R4 R11: two different duties on the shared count (scoreboard)
        idle(1200);

        // R2: period of 255 steps at reload 0
        write_reg(2'd1, 8'hFE);
        idle(600);
        measure(per, hi);
        check(per == 510, "R2", per, 510);
        check(hi == 2, "R2", hi, 2);

        // R3: division by reload+1 on the half-rate clock
        write_reg(2'd0, 8'd3);
        read_check(2'd0, 8'd3, "R8");
        idle(2100);
        measure(per, hi);
        check(per == 2040, "R3", per, 2040);
        check(hi == 8, "R3", hi, 8);

        // R6: FFh gives LOW over a whole period
        write_reg(2'd2, 8'hFF);
        count_level(1, 1'b1, 2100, seen);
        check(seen == 0, "R6", seen, 0);

        // R7: mid-period duty rewrites on both channels (scoreboard)
        write_reg(2'd1, 8'h10);
        idle(37);
        write_reg(2'd1, 8'hA0);
        write_reg(2'd2, 8'h05);
        idle(300);
        write_reg(2'd2, 8'h80);
        idle(500);

        // R9: reload change landing inside a long countdown (scoreboard)
        write_reg(2'd0, 8'd40);
        idle(500);
        write_reg(2'd0, 8'd1);
        read_check(2'd0, 8'd1, "R9");
        idle(23);
        write_reg(2'd0, 8'd6);
        idle(1500);

        // R8: writes to address 3 change no register
        write_reg(2'd3, 8'h00);
        read_check(2'd0, 8'd6, "R8");
        read_check(2'd1, 8'hA0, "R8");
        read_check(2'd2, 8'h80, "R8");

        // R1: reset mid-run restores HIGH outputs and cleared registers
        @(negedge clk); rst = 1'b1;
        idle(3);
        rst = 1'b0;
        read_check(2'd1, 8'h00, "R1");
        read_check(2'd0, 8'h00, "R1");
        idle(20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule